// File: doc/BRIEF.md
# Run/Halt and Single-Step Controller

This block governs whether the processor runs, stops, or yields the bus to the front panel. Two level switches select the policy: a halt/enable switch and a step-size switch that picks between stopping at instruction ends and stopping after each bus cycle. Two momentary keys arrive as single-cycle pulses. The continue key resumes or advances by one step, and the start key triggers a fixed-length system clear. The processor reports two boundaries through one-cycle strobes: a bus cycle has ended, and an instruction has ended.

While the halt switch is down, the controller raises one of two panel requests. The instruction-boundary request stops the machine at the next instruction end. The higher-priority cycle-boundary request stops it after the next bus cycle. A stop that lands between instructions leaves the address, examine, deposit and start keys locked. The continue key still works, so the operator can select instruction stepping and advance to an instruction end. When the clear ends, the controller either loads the program counter from the bus address register and runs, or reloads the bus address register from the temporary register and stays stopped.

The states are HALT_I (stopped at an instruction end, the reset state), HALT_C (stopped between instructions), RUN (running freely), STEP (running a single step) and CLEAR (system clear in progress). The transitions are:
- HALT_I to CLEAR on start.
- HALT_I or HALT_C to RUN on continue with enable selected.
- HALT_I or HALT_C to STEP on continue with halt selected.
- RUN or STEP to HALT_I or HALT_C on the armed boundary strobe. The target is HALT_I when the instruction-end strobe is high in that cycle.
- CLEAR to RUN or HALT_I when the clear timer expires.

Top module: `step_run_ctrl`

## Requirements
- R1: After reset the block is stopped at an instruction boundary. run_en, both requests, sys_clear, ld_pc and ld_bar are 0. keys_en equals halt_sw.
- R2: While running with halt_sw=0, run_en stays 1 and both requests stay 0, even when cyc_done and instr_done pulse.
- R3: While running with halt_sw=1 and cycle_sw=0, ibr_req is 1. A cyc_done pulse alone does not stop the machine. On an instr_done pulse, run_en falls in the next cycle and keys_en rises with it.
- R4: While running or stepping in cycle mode, cnpr_req is 1. After a cyc_done pulse the machine stops in the next cycle. keys_en is 1 after that stop only if instr_done was also high in the stopping cycle.
- R5: Continue with halt_sw=1 while stopped gives run_en=1 for a single step, with the request that matches cycle_sw. The step ends on the matching strobe, and the other strobe has no effect.
- R6: Continue with halt_sw=0 while stopped, at either kind of boundary, starts continuous running in the next cycle.
- R7: Continue and start pulses that arrive while running leave run_en at 1 and sys_clear at 0.
- R8: Start with halt_sw=0 at an instruction boundary gives sys_clear=1 for exactly 4 cycles with run_en=0. Running follows in the next cycle, and ld_pc=1 for that first cycle only.
- R9: Start with halt_sw=1 gives the same 4-cycle clear. The block then stays stopped with keys_en=1 and gives ld_bar=1 for one cycle.
- R10: While stopped between instructions, keys_en is 0 and start is ignored. Stepping in instruction mode from there reaches an instruction boundary and restores keys_en.
- R11: ibr_req and cnpr_req are never both 1. Neither is 1 while run_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| halt_sw | input | 1 | 1 selects halt, 0 selects enable |
| cycle_sw | input | 1 | 1 selects bus-cycle stepping, 0 selects instruction stepping |
| cont_key | input | 1 | Continue key, one-cycle pulse |
| start_key | input | 1 | Start key, one-cycle pulse |
| cyc_done | input | 1 | Bus cycle ended strobe |
| instr_done | input | 1 | Instruction ended strobe |
| run_en | output | 1 | Processor clock enabled |
| ibr_req | output | 1 | Panel request serviced at an instruction end |
| cnpr_req | output | 1 | Highest-priority panel request serviced after a bus cycle |
| sys_clear | output | 1 | System clear pulse |
| ld_pc | output | 1 | Load program counter from the bus address register |
| ld_bar | output | 1 | Load the bus address register from the temporary register |
| keys_en | output | 1 | Address, examine, deposit and start keys usable |

## Verification
The controller is driven through three ways of stopping. The first stops on an instruction end in instruction mode. The second stops on a bare bus-cycle end in cycle mode. The third stops on a bus-cycle end that coincides with an instruction end. Their results differ only in keys_en and in which request was raised. Each stepping run also pulses the strobe that does not belong to the current mode, which catches a design that stops on the wrong boundary. Start is pressed under both switch settings and at a cycle boundary, which separates the run path with ld_pc, the stay-stopped path with ld_bar, and the ignored case. Continue is pressed while running and while stopped at both kinds of boundary.

// File: rtl/rhc_pkg.sv
package rhc_pkg;

    typedef enum logic [2:0] {
        ST_HALT_I = 3'd0,
        ST_HALT_C = 3'd1,
        ST_RUN    = 3'd2,
        ST_STEP   = 3'd3,
        ST_CLEAR  = 3'd4
    } rhc_state_e;

endpackage

// File: rtl/rhc_clear_timer.sv
module rhc_clear_timer #(
    parameter int CLR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic last
);
    localparam int CW = $clog2(CLR_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(CLR_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/rhc_boundary.sv
module rhc_boundary (
    input  logic req_active,
    input  logic by_cycle,
    input  logic cyc_done,
    input  logic instr_done,
    output logic ibr,
    output logic cnpr,
    output logic hit,
    output logic at_instr
);
    always_comb begin
        ibr      = req_active && !by_cycle;
        cnpr     = req_active && by_cycle;
        hit      = req_active && (by_cycle ? cyc_done : instr_done);
        at_instr = instr_done;
    end
endmodule

// File: rtl/rhc_fsm.sv
module rhc_fsm
    import rhc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_sw,
    input  logic cycle_sw,
    input  logic cont_key,
    input  logic start_key,
    input  logic hit,
    input  logic at_instr,
    input  logic clr_last,
    output logic clr_load,
    output logic req_active,
    output logic by_cycle,
    output logic run_en,
    output logic sys_clear,
    output logic ld_pc,
    output logic ld_bar,
    output logic keys_en
);
    rhc_state_e state_q, state_d;
    logic       step_cyc_q, step_cyc_d;
    logic       start_run_q, start_run_d;
    logic       post_clr_q, post_clr_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_HALT_I;
            step_cyc_q  <= 1'b0;
            start_run_q <= 1'b0;
            post_clr_q  <= 1'b0;
        end else begin
            state_q     <= state_d;
            step_cyc_q  <= step_cyc_d;
            start_run_q <= start_run_d;
            post_clr_q  <= post_clr_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        step_cyc_d  = step_cyc_q;
        start_run_d = start_run_q;
        post_clr_d  = 1'b0;
        clr_load    = 1'b0;
        unique case (state_q)
            ST_HALT_I: begin
                if (start_key) begin
                    state_d     = ST_CLEAR;
                    start_run_d = !halt_sw;
                    clr_load    = 1'b1;
                end else if (cont_key) begin
                    state_d    = halt_sw ? ST_STEP : ST_RUN;
                    step_cyc_d = cycle_sw;
                end
            end
            ST_HALT_C: begin
                if (cont_key) begin
                    state_d    = halt_sw ? ST_STEP : ST_RUN;
                    step_cyc_d = cycle_sw;
                end
            end
            ST_RUN, ST_STEP: begin
                if (hit) begin
                    state_d = at_instr ? ST_HALT_I : ST_HALT_C;
                end
            end
            ST_CLEAR: begin
                if (clr_last) begin
                    state_d    = start_run_q ? ST_RUN : ST_HALT_I;
                    post_clr_d = 1'b1;
                end
            end
            default: state_d = ST_HALT_I;
        endcase
    end

    always_comb begin
        req_active = 1'b0;
        by_cycle   = 1'b0;
        run_en     = 1'b0;
        sys_clear  = 1'b0;
        ld_pc      = 1'b0;
        ld_bar     = 1'b0;
        keys_en    = 1'b0;
        unique case (state_q)
            ST_HALT_I: begin
                keys_en = halt_sw;
                ld_bar  = post_clr_q;
            end
            ST_HALT_C: begin
            end
            ST_RUN: begin
                run_en     = 1'b1;
                req_active = halt_sw;
                by_cycle   = cycle_sw;
                ld_pc      = post_clr_q;
            end
            ST_STEP: begin
                run_en     = 1'b1;
                req_active = 1'b1;
                by_cycle   = step_cyc_q;
            end
            ST_CLEAR: begin
                sys_clear = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/step_run_ctrl.sv
module step_run_ctrl #(
    parameter int CLR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_sw,
    input  logic cycle_sw,
    input  logic cont_key,
    input  logic start_key,
    input  logic cyc_done,
    input  logic instr_done,
    output logic run_en,
    output logic ibr_req,
    output logic cnpr_req,
    output logic sys_clear,
    output logic ld_pc,
    output logic ld_bar,
    output logic keys_en
);
    logic hit, at_instr, clr_last, clr_load, req_active, by_cycle;

    rhc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_sw    (halt_sw),
        .cycle_sw   (cycle_sw),
        .cont_key   (cont_key),
        .start_key  (start_key),
        .hit        (hit),
        .at_instr   (at_instr),
        .clr_last   (clr_last),
        .clr_load   (clr_load),
        .req_active (req_active),
        .by_cycle   (by_cycle),
        .run_en     (run_en),
        .sys_clear  (sys_clear),
        .ld_pc      (ld_pc),
        .ld_bar     (ld_bar),
        .keys_en    (keys_en)
    );

    rhc_boundary u_bnd (
        .req_active (req_active),
        .by_cycle   (by_cycle),
        .cyc_done   (cyc_done),
        .instr_done (instr_done),
        .ibr        (ibr_req),
        .cnpr       (cnpr_req),
        .hit        (hit),
        .at_instr   (at_instr)
    );

    rhc_clear_timer #(.CLR_CYCLES(CLR_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (clr_load),
        .last  (clr_last)
    );
endmodule

// File: rtl/rhc_checker.sv
module rhc_checker #(
    parameter int CLR_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic halt_sw,
    input logic cont_key,
    input logic cyc_done,
    input logic instr_done,
    input logic run_en,
    input logic ibr_req,
    input logic cnpr_req,
    input logic sys_clear,
    input logic ld_pc,
    input logic ld_bar,
    input logic keys_en
);
    localparam int LW = $clog2(CLR_CYCLES + 2);

    logic [LW-1:0] clr_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_len <= '0;
        end else if (!sys_clear) begin
            clr_len <= '0;
        end else if (clr_len != {LW{1'b1}}) begin
            clr_len <= clr_len + 1'b1;
        end
    end

    assert_req_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ibr_req, cnpr_req}));

    assert_no_req_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (!ibr_req && !cnpr_req));

    assert_clear_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clear |-> (!run_en && !keys_en));

    assert_clear_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_clear) |-> (clr_len == LW'(CLR_CYCLES)));

    assert_clear_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_clear |-> (clr_len < LW'(CLR_CYCLES)));

    assert_after_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_clear) |-> ((ld_pc && run_en) || (ld_bar && !run_en)));

    assert_keys_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        keys_en |-> (!run_en && halt_sw));

    assert_cont_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && cont_key && !cyc_done && !instr_done) |=> run_en);
endmodule

bind step_run_ctrl rhc_checker #(.CLR_CYCLES(CLR_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_sw    (halt_sw),
    .cont_key   (cont_key),
    .cyc_done   (cyc_done),
    .instr_done (instr_done),
    .run_en     (run_en),
    .ibr_req    (ibr_req),
    .cnpr_req   (cnpr_req),
    .sys_clear  (sys_clear),
    .ld_pc      (ld_pc),
    .ld_bar     (ld_bar),
    .keys_en    (keys_en)
);

// File: tb/tb_step_run_ctrl.sv
module tb_step_run_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_sw = 1'b1, cycle_sw = 1'b0, cont_key = 1'b0, start_key = 1'b0;
    logic cyc_done = 1'b0, instr_done = 1'b0;
    logic run_en, ibr_req, cnpr_req, sys_clear, ld_pc, ld_bar, keys_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    step_run_ctrl dut (
        .clk(clk), .rst_n(rst_n), .halt_sw(halt_sw), .cycle_sw(cycle_sw),
        .cont_key(cont_key), .start_key(start_key), .cyc_done(cyc_done),
        .instr_done(instr_done), .run_en(run_en), .ibr_req(ibr_req),
        .cnpr_req(cnpr_req), .sys_clear(sys_clear), .ld_pc(ld_pc),
        .ld_bar(ld_bar), .keys_en(keys_en)
    );

    // Monitor: output vector is {run_en, ibr_req, cnpr_req, sys_clear, ld_pc, ld_bar, keys_en}
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [6:0] act;
            it  = sb_q.pop_front();
            act = {run_en, ibr_req, cnpr_req, sys_clear, ld_pc, ld_bar, keys_en};
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
            end
        end
    end

    // Driver: inputs are {halt_sw, cycle_sw, cont_key, start_key, cyc_done, instr_done}
    task automatic cyc(input logic [5:0] in, input logic [6:0] exp, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        {halt_sw, cycle_sw, cont_key, start_key, cyc_done, instr_done} = in;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        cyc(6'b100000, 7'b0000001, "R1 reset keys with halt");
        cyc(6'b000000, 7'b0000000, "R1 reset keys with enable");
        // R8 start in enable mode
        cyc(6'b000100, 7'b0000000, "R8 start press");
        for (int i = 0; i < 4; i++) cyc(6'b000000, 7'b0001000, "R8 clear window");
        cyc(6'b000000, 7'b1000100, "R8 run with ld_pc");
        cyc(6'b000000, 7'b1000000, "R8 ld_pc single cycle");
        // R2 strobes in enable mode
        cyc(6'b000011, 7'b1000000, "R2 strobes while enabled");
        cyc(6'b000000, 7'b1000000, "R2 still running");
        // R7 keys while running
        cyc(6'b001000, 7'b1000000, "R7 cont while running");
        cyc(6'b000000, 7'b1000000, "R7 after cont");
        cyc(6'b000100, 7'b1000000, "R7 start while running");
        cyc(6'b000000, 7'b1000000, "R7 no clear after start");
        // R3 halt in instruction mode
        cyc(6'b100000, 7'b1100000, "R3 ibr raised");
        cyc(6'b100010, 7'b1100000, "R3 cycle end alone");
        cyc(6'b100000, 7'b1100000, "R3 not stopped by cycle end");
        cyc(6'b100001, 7'b1100000, "R3 instruction end");
        cyc(6'b100000, 7'b0000001, "R3 stopped with keys");
        // R5 single cycle step, R4 stop between instructions
        cyc(6'b111000, 7'b0000001, "R5 cont press cycle mode");
        cyc(6'b110000, 7'b1010000, "R5 cycle step running");
        cyc(6'b110010, 7'b1010000, "R5 cycle end");
        cyc(6'b110000, 7'b0000000, "R4 stop between instructions");
        // R10 start ignored between instructions
        cyc(6'b110100, 7'b0000000, "R10 start between instructions");
        cyc(6'b110000, 7'b0000000, "R10 no clear");
        // R4 coincident boundary
        cyc(6'b111000, 7'b0000000, "R4 cont press");
        cyc(6'b110011, 7'b1010000, "R4 both strobes");
        cyc(6'b110000, 7'b0000001, "R4 stop at instruction end");
        // R5 and R10 move from cycle boundary to instruction boundary
        cyc(6'b111000, 7'b0000001, "R5 cont press again");
        cyc(6'b110010, 7'b1010000, "R5 step ends on cycle");
        cyc(6'b110000, 7'b0000000, "R10 locked between instructions");
        cyc(6'b101000, 7'b0000000, "R10 cont instruction mode");
        cyc(6'b100010, 7'b1100000, "R5 cycle end ignored in instr step");
        cyc(6'b100001, 7'b1100000, "R5 instruction end");
        cyc(6'b100000, 7'b0000001, "R10 keys restored");
        // R9 start in halt mode
        cyc(6'b100100, 7'b0000001, "R9 start press");
        for (int i = 0; i < 4; i++) cyc(6'b100000, 7'b0001000, "R9 clear window");
        cyc(6'b100000, 7'b0000011, "R9 ld_bar and stopped");
        cyc(6'b100000, 7'b0000001, "R9 ld_bar single cycle");
        // R6 continue in enable mode, then cycle-mode stop while running
        cyc(6'b001000, 7'b0000000, "R6 cont press enable");
        cyc(6'b000000, 7'b1000000, "R6 running");
        cyc(6'b000011, 7'b1000000, "R2 strobes again");
        cyc(6'b110000, 7'b1010000, "R4 cnpr while running");
        cyc(6'b110010, 7'b1010000, "R4 cycle end while running");
        cyc(6'b110000, 7'b0000000, "R4 stopped mid instruction");
        cyc(6'b011000, 7'b0000000, "R6 cont from cycle stop");
        cyc(6'b010000, 7'b1000000, "R6 running from cycle stop R11");
        cyc(6'b010010, 7'b1000000, "R11 no request in enable");
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule